// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. A lookup presents a virtual page number with an address-space identifier. Every stored entry is compared against both at once. When an entry matches, its physical frame number is returned on the next clock edge. When nothing matches, the block holds the request, asks an external page-table walker for the frame, writes the answer into the cache, and then returns the frame to the requester.

An entry can be installed as wired, which means it is pinned. Pinned entries are never chosen for replacement and are never cleared by a flush. When a fill arrives, an empty slot is used if one exists. If every slot is full, a round-robin pointer picks the next slot that is not pinned. If every slot is pinned, the walked translation is still returned but is not stored.

There are two flush inputs. One clears every unpinned entry, and the other clears only the unpinned entries of one identifier. Both take effect at a single clock edge.

Top module: `asid_tlb`

## Requirements
- R1: If a valid entry matches both `req_vpn` and `req_asid` in the cycle `req_valid` is accepted, then one cycle later `resp_valid`=1, `resp_hit`=1 and `resp_pfn` is the stored frame, and no walk is requested.
- R2: An entry whose identifier differs from `req_asid` never produces a hit, even when its page number matches.
- R3: On a miss, from the next cycle `busy`=1 and `walk_req_valid`=1, with `walk_req_vpn`/`walk_req_asid` equal to the request. These hold unchanged until `walk_rsp_valid` is seen.
- R4: One cycle after `walk_rsp_valid`, `resp_valid`=1, `resp_hit`=0, `resp_pfn` equals `walk_rsp_pfn` and `busy`=0. The translation is then stored, so a repeat lookup hits.
- R5: A fill takes the lowest-numbered empty slot. When there is no empty slot, it takes the first unpinned slot at or after a round-robin pointer. The pointer is 0 after reset and moves to the slot after each replaced one.
- R6: An entry filled with `walk_rsp_wired`=1 is never replaced.
- R7: When all slots are pinned, a fill still returns its frame (R4) but stores nothing, so a repeat lookup misses again.
- R8: A one-cycle pulse on `flush_all` invalidates every unpinned entry and leaves pinned entries valid.
- R9: A one-cycle pulse on `flush_asid_en` invalidates only the unpinned entries whose identifier equals `flush_asid`.
- R10: `req_valid` is ignored while `busy`=1. It produces no response and no change to the pending walk.
- R11: After reset, all entries are invalid and `resp_valid`, `busy` and `walk_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request, accepted when not busy |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_asid | input | ASID_W | Address-space identifier of the request |
| resp_valid | output | 1 | One-cycle pulse: translation result present |
| resp_hit | output | 1 | 1 when the result came from the cache, 0 when it came from a walk |
| resp_pfn | output | PFN_W | Translated frame number |
| busy | output | 1 | A miss is waiting for the walker |
| walk_req_valid | output | 1 | Request to the page-table walker |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_req_asid | output | ASID_W | Identifier of the page to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_pfn | input | PFN_W | Frame returned by the walker |
| walk_rsp_wired | input | 1 | Install the fill as pinned |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_en | input | 1 | Invalidate unpinned entries of one identifier |
| flush_asid | input | ASID_W | Identifier selected for flushing |

## Verification
A hit result is due exactly one edge after the request is accepted. A miss shows `busy` and the walk request one edge after the request, and the filled result appears one edge after the walker answer. The bench drives every input on a falling edge and samples on the following falling edge, so every check falls half a period after the single register stage that produces the value. Eviction order, pinning and flush effects are observed only through later lookups: a hit within one edge means the entry survived, and a raised walk request means it is gone.

// File: rtl/tlb_pkg.sv
// Shared types for the address-space-tagged translation cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tlb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage with a parallel tag compare.
// Each entry holds a valid bit, a pinned bit, the page number, the identifier
// and the frame. Lookup is combinational on the presented key. Flushes and
// the single write port act at the clock edge; a write overrides a flush on
// the same slot. Assumes at most one entry matches any key, which holds
// because fills happen only after a miss.
module tlb_entry_store #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_wired,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic [N-1:0]      valid_vec,
    output logic [N-1:0]      wired_vec
);
    logic [VPN_W-1:0]  vpn_q  [N];
    logic [ASID_W-1:0] asid_q [N];
    logic [PFN_W-1:0]  pfn_q  [N];
    logic [N-1:0]      hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic kill;

        // Decide whether a flush clears this entry (pinned entries are exempt).
        always_comb begin
            kill = !wired_vec[i] &&
                   (flush_all || (flush_asid_en && (asid_q[i] == flush_asid)));
        end

        // Per-entry state update: reset, flush, then fill write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
                wired_vec[i] <= 1'b0;
                vpn_q[i]     <= '0;
                asid_q[i]    <= '0;
                pfn_q[i]     <= '0;
            end else begin
                if (kill) begin
                    valid_vec[i] <= 1'b0;
                end
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    valid_vec[i] <= 1'b1;
                    wired_vec[i] <= wr_wired;
                    vpn_q[i]     <= wr_vpn;
                    asid_q[i]    <= wr_asid;
                    pfn_q[i]     <= wr_pfn;
                end
            end
        end

        // Tag compare: page number and identifier must both match.
        always_comb begin
            hit_vec[i] = valid_vec[i] && (vpn_q[i] == lk_vpn) && (asid_q[i] == lk_asid);
        end

        // R6: a pinned entry keeps its contents for as long as it exists.
        assert_pinned_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_vec[i] && wired_vec[i]) |=>
            (valid_vec[i] && wired_vec[i] && $stable(vpn_q[i]) &&
             $stable(asid_q[i]) && $stable(pfn_q[i])))
            else $error("pinned entry %0d changed", i);
    end

    // Merge the matching frame into one output.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
        lk_hit = |hit_vec;
    end

    // R1/R2: no key ever matches two entries.
    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec))
        else $error("multiple entries match one key");
endmodule

// File: rtl/tlb_victim_pick.sv
// Replacement slot selection.
// Prefers the lowest-numbered empty slot. When no slot is empty, it scans from
// a round-robin pointer for the first unpinned slot. The pointer advances past
// a slot only when that slot is actually replaced. Assumes N >= 2.
module tlb_victim_pick #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     wired_vec,
    input  logic             commit,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_ok
);
    localparam logic [IDX_W:0]   N_EXT = (IDX_W+1)'(N);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx, rot_idx;
    logic             free_found, rot_found;
    logic [IDX_W:0]   cand;

    // Search for an empty slot and for the next unpinned slot from the pointer.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        rot_found = 1'b0;
        rot_idx   = '0;
        cand      = '0;
        for (int k = N - 1; k >= 0; k--) begin
            cand = {1'b0, rr_q} + (IDX_W+1)'(k);
            if (cand >= N_EXT) cand = cand - N_EXT;
            if (!wired_vec[cand[IDX_W-1:0]]) begin
                rot_found = 1'b1;
                rot_idx   = cand[IDX_W-1:0];
            end
        end
        victim_ok  = free_found || rot_found;
        victim_idx = free_found ? free_idx : rot_idx;
    end

    // Advance the round-robin pointer after a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (commit && !free_found && rot_found) begin
            rr_q <= (rot_idx == LAST) ? '0 : rot_idx + 1'b1;
        end
    end

    // R6: the chosen slot never holds a live pinned entry.
    assert_victim_unpinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && victim_ok) |-> !(valid_vec[victim_idx] && wired_vec[victim_idx]))
        else $error("pinned slot chosen for replacement");
endmodule

// File: rtl/tlb_ctrl.sv
// Lookup and miss sequencing.
// In idle it accepts a request, answers a hit on the next edge, or starts a
// walk. While walking it holds the request for the walker, ignores new
// requests, and on the walker answer writes the fill and returns the frame.
// Assumes the walker answers only while its request is raised.
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              lk_hit,
    input  logic [PFN_W-1:0]  lk_pfn,
    input  logic              walk_rsp_valid,
    input  logic [PFN_W-1:0]  walk_rsp_pfn,
    input  logic              victim_ok,
    output logic              fill_en,
    output logic              fill_commit,
    output logic [VPN_W-1:0]  pend_vpn,
    output logic [ASID_W-1:0] pend_asid,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [PFN_W-1:0]  resp_pfn,
    output logic              busy,
    output logic              walk_req_valid
);
    tlb_state_e state_q;

    // Fill strobes: a walker answer always completes; it is stored only if a slot exists.
    always_comb begin
        fill_commit = (state_q == ST_WALK) && walk_rsp_valid;
        fill_en     = fill_commit && victim_ok;
    end

    // Sequencing of requests, hits, walks and responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_vpn   <= '0;
            pend_asid  <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_pfn   <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        pend_vpn  <= req_vpn;
                        pend_asid <= req_asid;
                        if (lk_hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_pfn   <= lk_pfn;
                        end else begin
                            state_q <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_rsp_valid) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_pfn   <= walk_rsp_pfn;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Walk request and busy flag follow the state.
    always_comb begin
        busy           = (state_q == ST_WALK);
        walk_req_valid = busy;
    end

    // R3: an unanswered walk request stays raised with the same key.
    assert_walk_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=>
        (walk_req_valid && $stable(pend_vpn) && $stable(pend_asid)))
        else $error("walk request dropped or changed");

    // R4: a walker answer completes the miss on the next edge.
    assert_fill_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid) |=> (resp_valid && !resp_hit && !busy))
        else $error("fill did not complete");

    // R10: while a walk waits, no response is produced.
    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_rsp_valid) |=> !resp_valid)
        else $error("response while busy");
endmodule

// File: rtl/asid_tlb.sv
// Top of the address-space-tagged translation cache.
// Connects the entry store, the replacement picker and the sequencer.
// A flush in the same cycle as a lookup acts on the edge, after that lookup
// has been compared against the old contents.
module asid_tlb #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [PFN_W-1:0]  resp_pfn,
    output logic              busy,
    output logic              walk_req_valid,
    output logic [VPN_W-1:0]  walk_req_vpn,
    output logic [ASID_W-1:0] walk_req_asid,
    input  logic              walk_rsp_valid,
    input  logic [PFN_W-1:0]  walk_rsp_pfn,
    input  logic              walk_rsp_wired,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    localparam int IDX_W = $clog2(N);

    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             fill_en, fill_commit, victim_ok;
    logic [IDX_W-1:0] victim_idx;
    logic [N-1:0]     valid_vec, wired_vec;

    tlb_entry_store #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_vpn), .lk_asid(req_asid), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .wr_en(fill_en), .wr_idx(victim_idx), .wr_vpn(walk_req_vpn),
        .wr_asid(walk_req_asid), .wr_pfn(walk_rsp_pfn), .wr_wired(walk_rsp_wired),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
        .valid_vec(valid_vec), .wired_vec(wired_vec)
    );

    tlb_victim_pick #(.N(N)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .valid_vec(valid_vec), .wired_vec(wired_vec), .commit(fill_commit),
        .victim_idx(victim_idx), .victim_ok(victim_ok)
    );

    tlb_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_asid(req_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .victim_ok(victim_ok), .fill_en(fill_en), .fill_commit(fill_commit),
        .pend_vpn(walk_req_vpn), .pend_asid(walk_req_asid),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pfn(resp_pfn),
        .busy(busy), .walk_req_valid(walk_req_valid)
    );

    // R11: nothing is pending or reported in the cycle after reset.
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !busy && !walk_req_valid))
        else $error("outputs active after reset");
endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
    localparam int VW = 20;
    localparam int AW = 8;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vpn = '0;
    logic [AW-1:0] req_asid = '0;
    logic          resp_valid, resp_hit, busy, walk_req_valid;
    logic [PW-1:0] resp_pfn;
    logic [VW-1:0] walk_req_vpn;
    logic [AW-1:0] walk_req_asid;
    logic          walk_rsp_valid = 1'b0;
    logic [PW-1:0] walk_rsp_pfn = '0;
    logic          walk_rsp_wired = 1'b0;
    logic          flush_all = 1'b0;
    logic          flush_asid_en = 1'b0;
    logic [AW-1:0] flush_asid = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_asid(req_asid),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pfn(resp_pfn),
        .busy(busy), .walk_req_valid(walk_req_valid),
        .walk_req_vpn(walk_req_vpn), .walk_req_asid(walk_req_asid),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_wired(walk_rsp_wired),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Walker answers; result is due one edge later.
    task automatic give_fill(input logic [PW-1:0] pfn, input bit wired, input string rq);
        walk_rsp_valid = 1'b1;
        walk_rsp_pfn   = pfn;
        walk_rsp_wired = wired;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        walk_rsp_wired = 1'b0;
        check(rq, "fill resp_valid", 32'(resp_valid), 1);
        check(rq, "fill resp_hit", 32'(resp_hit), 0);
        check(rq, "fill resp_pfn", 32'(resp_pfn), 32'(pfn));
        check(rq, "fill busy", 32'(busy), 0);
    endtask

    // One lookup; exp_hit selects whether a cache answer or a walk is expected.
    task automatic lookup(input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                          input bit exp_hit, input logic [PW-1:0] pfn,
                          input bit wired, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = vpn;
        req_asid  = asid;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            check(rq, "hit resp_valid", 32'(resp_valid), 1);
            check(rq, "hit resp_hit", 32'(resp_hit), 1);
            check(rq, "hit resp_pfn", 32'(resp_pfn), 32'(pfn));
            check(rq, "hit no walk", 32'(walk_req_valid), 0);
            if (busy) give_fill(pfn, 1'b0, rq);
        end else begin
            check(rq, "miss busy", 32'(busy), 1);
            check(rq, "miss walk_req_valid", 32'(walk_req_valid), 1);
            check(rq, "miss walk vpn", 32'(walk_req_vpn), 32'(vpn));
            check(rq, "miss walk asid", 32'(walk_req_asid), 32'(asid));
            check(rq, "miss no resp", 32'(resp_valid), 0);
            repeat (2) @(negedge clk);
            check("R3", "walk held", 32'(walk_req_valid), 1);
            check("R3", "walk vpn held", 32'(walk_req_vpn), 32'(vpn));
            give_fill(pfn, wired, rq);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11", "resp_valid", 32'(resp_valid), 0);
        check("R11", "busy", 32'(busy), 0);
        check("R11", "walk_req_valid", 32'(walk_req_valid), 0);
        lookup(20'h00000, 8'h00, 1'b0, 20'h0CAFE, 1'b0, "R11");
    endtask

    task automatic t_miss_then_hit();
        do_reset();
        lookup(20'h12345, 8'h01, 1'b0, 20'hABCDE, 1'b0, "R3");
        lookup(20'h12345, 8'h01, 1'b1, 20'hABCDE, 1'b0, "R4");
        lookup(20'h12345, 8'h01, 1'b1, 20'hABCDE, 1'b0, "R1");
        lookup(20'h12346, 8'h01, 1'b0, 20'h00111, 1'b0, "R1");
        lookup(20'h12345, 8'h01, 1'b1, 20'hABCDE, 1'b0, "R1");
        lookup(20'h12346, 8'h01, 1'b1, 20'h00111, 1'b0, "R1");
    endtask

    task automatic t_asid_tag();
        do_reset();
        lookup(20'h00042, 8'h01, 1'b0, 20'h11111, 1'b0, "R2");
        lookup(20'h00042, 8'h02, 1'b0, 20'h22222, 1'b0, "R2");
        lookup(20'h00042, 8'h01, 1'b1, 20'h11111, 1'b0, "R2");
        lookup(20'h00042, 8'h02, 1'b1, 20'h22222, 1'b0, "R2");
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 8; i++)
            lookup(20'h00100 + 20'(i), 8'h01, 1'b0, 20'h01100 + 20'(i), 1'b0, "R5");
        lookup(20'h00200, 8'h01, 1'b0, 20'h02200, 1'b0, "R5");   // replaces slot 0
        lookup(20'h00101, 8'h01, 1'b1, 20'h01101, 1'b0, "R5");
        lookup(20'h00200, 8'h01, 1'b1, 20'h02200, 1'b0, "R5");
        lookup(20'h00100, 8'h01, 1'b0, 20'h01100, 1'b0, "R5");   // replaces slot 1
        lookup(20'h00102, 8'h01, 1'b1, 20'h01102, 1'b0, "R5");
        lookup(20'h00101, 8'h01, 1'b0, 20'h01101, 1'b0, "R5");   // replaces slot 2
    endtask

    task automatic t_pinned();
        do_reset();
        lookup(20'h00300, 8'h03, 1'b0, 20'h03300, 1'b1, "R6");
        for (int i = 1; i < 8; i++)
            lookup(20'h00300 + 20'(i), 8'h03, 1'b0, 20'h03300 + 20'(i), 1'b0, "R6");
        lookup(20'h00400, 8'h03, 1'b0, 20'h04400, 1'b0, "R6");   // skips pinned slot 0
        lookup(20'h00300, 8'h03, 1'b1, 20'h03300, 1'b0, "R6");
        lookup(20'h00400, 8'h03, 1'b1, 20'h04400, 1'b0, "R6");
        lookup(20'h00301, 8'h03, 1'b0, 20'h03301, 1'b0, "R6");
        lookup(20'h00303, 8'h03, 1'b1, 20'h03303, 1'b0, "R6");
        lookup(20'h00300, 8'h03, 1'b1, 20'h03300, 1'b0, "R6");
    endtask

    task automatic t_all_pinned();
        do_reset();
        for (int i = 0; i < 8; i++)
            lookup(20'h00500 + 20'(i), 8'h05, 1'b0, 20'h05500 + 20'(i), 1'b1, "R7");
        lookup(20'h00600, 8'h05, 1'b0, 20'h06600, 1'b0, "R7");
        lookup(20'h00600, 8'h05, 1'b0, 20'h06600, 1'b0, "R7");
        lookup(20'h00500, 8'h05, 1'b1, 20'h05500, 1'b0, "R7");
        lookup(20'h00507, 8'h05, 1'b1, 20'h05507, 1'b0, "R7");
    endtask

    task automatic t_flush_all();
        do_reset();
        lookup(20'h00700, 8'h01, 1'b0, 20'h07700, 1'b0, "R8");
        lookup(20'h00701, 8'h01, 1'b0, 20'h07701, 1'b1, "R8");
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        lookup(20'h00701, 8'h01, 1'b1, 20'h07701, 1'b0, "R8");
        lookup(20'h00700, 8'h01, 1'b0, 20'h07700, 1'b0, "R8");
    endtask

    task automatic t_flush_asid();
        do_reset();
        lookup(20'h00800, 8'h01, 1'b0, 20'h08800, 1'b0, "R9");
        lookup(20'h00801, 8'h02, 1'b0, 20'h08801, 1'b0, "R9");
        lookup(20'h00802, 8'h02, 1'b0, 20'h08802, 1'b1, "R9");
        @(negedge clk);
        flush_asid_en = 1'b1;
        flush_asid    = 8'h02;
        @(negedge clk);
        flush_asid_en = 1'b0;
        lookup(20'h00800, 8'h01, 1'b1, 20'h08800, 1'b0, "R9");
        lookup(20'h00802, 8'h02, 1'b1, 20'h08802, 1'b0, "R9");
        lookup(20'h00801, 8'h02, 1'b0, 20'h08801, 1'b0, "R9");
    endtask

    task automatic t_busy_ignore();
        do_reset();
        lookup(20'h00900, 8'h01, 1'b0, 20'h09900, 1'b0, "R10");
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = 20'h00A00;
        req_asid  = 8'h01;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "busy after miss", 32'(busy), 1);
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = 20'h00900;           // would hit if not ignored
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "no resp while busy", 32'(resp_valid), 0);
        check("R10", "walk vpn unchanged", 32'(walk_req_vpn), 32'h00A00);
        give_fill(20'h0AA00, 1'b0, "R10");
        @(negedge clk);
        check("R10", "no late resp", 32'(resp_valid), 0);
        check("R10", "no new walk", 32'(walk_req_valid), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL all: watchdog expired, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_miss_then_hit();
        t_asid_tag();
        t_round_robin();
        t_pinned();
        t_all_pinned();
        t_flush_all();
        t_flush_asid();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule